// File: doc/BRIEF.md
# Byte-Lane Write Qualifier

This block sits on the subordinate side of a pipelined system bus with separate address and data phases. It works out which byte lanes of a 32-bit write data bus really hold data to be stored. During the address phase it records the low address bits, the transfer size and the word index. In the following data phase it combines them with the manager's per-byte write strobes and a static endianness setting. The result is a per-lane write enable, which updates one word of a small register bank.

The address window decides which lanes *may* be used. The strobes then pick a subset of that window. A strobe bit outside the window is legal and is silently ignored, so a manager that ties its strobes high still behaves correctly. The subordinate never inserts wait states. It honours the shared ready input in both phases: an address phase is only taken while ready is high, and a data phase that sees ready low is held until ready returns. A debug read port returns the stored words.

Top module: `byte_lane_qual`

## Requirements
- R1: An address phase is captured only when `bus_sel`, `bus_ready_in` and `bus_write` are high and `bus_trans` is 2'b10 (first beat) or 2'b11 (continuing beat). Idle (2'b00), busy (2'b01), read or unselected phases cause no write.
- R2: A captured write is applied in the next cycle in which `bus_ready_in` is high, which is normally the cycle right after capture. `lane_we` is valid in that cycle, and the bank updates at its closing edge.
- R3: A byte lane is written only if the captured address and size permit it and its `bus_wstrb` bit is set. Lane k is `bus_wdata[8k+7:8k]`.
- R4: Strobe bits outside the permitted lanes are accepted and have no effect. For example, a halfword at offset 2 with strobe 4'b0111 writes only lane 2.
- R5: Size code 0 (byte) permits one lane. Size code 1 (halfword) permits two lanes. Size code 2 (word) and any larger code permit all four lanes.
- R6: In little-endian and byte-invariant big-endian modes, a byte at offset k uses lane k. A halfword with address bit 1 = 0 uses lanes 1:0, and with bit 1 = 1 uses lanes 3:2.
- R7: In word-invariant big-endian mode the permitted lanes are mirrored within the word: byte offset k uses lane 3-k, and a halfword with address bit 1 = 0 uses lanes 3:2.
- R8: With all strobes set, exactly the permitted lanes are written, for every size, offset and mode.
- R9: `endian_mode` encodes 2'b00 little-endian, 2'b01 byte-invariant big-endian and 2'b10 word-invariant big-endian. Code 2'b11 behaves as little-endian.
- R10: Address bits [3:2] select one of four bank words. All words reset to zero, and `rd_data` returns the word chosen by `rd_idx`.
- R11: While a pending data phase sees `bus_ready_in` low, `lane_we` stays zero and the captured control is held. The write happens in the first cycle in which ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| endian_mode | input | 2 | Static endianness setting (R9) |
| bus_sel | input | 1 | Subordinate selected in the address phase |
| bus_ready_in | input | 1 | Shared bus ready; low stalls the current phase |
| bus_write | input | 1 | Address phase is a write |
| bus_trans | input | 2 | Transfer type of the address phase |
| bus_addr | input | 4 | Word index [3:2] and byte offset [1:0] |
| bus_size | input | 3 | Transfer size code |
| bus_wdata | input | 32 | Data-phase write data |
| bus_wstrb | input | 4 | Data-phase per-byte strobes |
| lane_we | output | 4 | Final per-lane write enable |
| rd_idx | input | 2 | Debug read word select |
| rd_data | output | 32 | Debug read data |

## Verification
The hardest case to reach is a data phase held by a low ready input while the address/data overlap keeps changing the address-side signals. The capture must hold, and the enables must stay quiet until ready returns. The stimulus drives a stalled data phase of several cycles, with the idle address-side inputs changed during the stall, and expects zero enables on each stalled cycle. Strobes that are deliberately wider than the window, in all three endian modes, show that lanes outside the window are ignored. After every transfer the debug port reads the bank back, so an unwanted lane write shows up even when the enable vector looked right.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef enum logic [1:0] {
    END_LITTLE   = 2'b00,
    END_BYTE_INV = 2'b01,
    END_WORD_INV = 2'b10,
    END_RSVD     = 2'b11
  } endian_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
endpackage

// File: rtl/bq_lane_window.sv
module bq_lane_window
  import bq_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFFW = $clog2(LANES)
) (
  input  logic [OFFW-1:0]  off,
  input  logic [2:0]       size,
  input  endian_e          mode,
  output logic [LANES-1:0] permit
);
  logic [2:0]       sz_eff;
  logic [LANES-1:0] linear;

  // Sizes at or beyond the bus width open the whole word.
  always_comb begin
    if (size > 3'(OFFW)) sz_eff = 3'(OFFW);
    else                 sz_eff = size;
  end

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      localparam logic [OFFW-1:0] LIDX = OFFW'(i);
      // A lane is inside the window when it shares the aligned block of the offset.
      assign linear[i] = ((LIDX >> sz_eff) == (off >> sz_eff));
      // Word-invariant big-endian mirrors the lane order inside the word.
      assign permit[i] = (mode == END_WORD_INV) ? linear[LANES-1-i] : linear[i];
    end
  endgenerate
endmodule

// File: rtl/bq_addr_capture.sv
module bq_addr_capture
  import bq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WORDS = 4,
  localparam int OFFW = $clog2(LANES),
  localparam int IDXW = $clog2(WORDS),
  localparam int AW   = OFFW + IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            ready_in,
  input  logic            write,
  input  logic [1:0]      trans,
  input  logic [AW-1:0]   addr,
  input  logic [2:0]      size,
  output logic            dphase,
  output logic [OFFW-1:0] cap_off,
  output logic [IDXW-1:0] cap_idx,
  output logic [2:0]      cap_size
);
  logic take;

  assign take = sel && ready_in && write &&
                (trans == TR_NONSEQ || trans == TR_SEQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dphase   <= 1'b0;
      cap_off  <= '0;
      cap_idx  <= '0;
      cap_size <= '0;
    end else if (ready_in) begin
      dphase <= take;
      if (take) begin
        cap_off  <= addr[OFFW-1:0];
        cap_idx  <= addr[AW-1:OFFW];
        cap_size <= size;
      end
    end
  end

  // R1: a qualifying write address phase opens a data phase
  a_r1_capture_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ready_in && write && trans[1]) |=> dphase);

  // R1: no data phase follows a read while ready is high
  a_r1_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_in && !write) |=> !dphase);

  // R11: a stalled data phase keeps its captured control
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dphase && !ready_in) |=> (dphase && $stable(cap_idx) && $stable(cap_off) && $stable(cap_size)));
endmodule

// File: rtl/bq_word_bank.sv
module bq_word_bank #(
  parameter int LANES = 4,
  parameter int WORDS = 4,
  localparam int DW   = LANES * 8,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] we,
  input  logic [IDXW-1:0]  idx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0]      mem [WORDS];
  logic [WORDS*8-1:0] col [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (we[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
    end
  end

  assign rd_data = mem[rd_idx];

  // One column per lane across all words, for the lane-quiet checks.
  always_comb begin
    for (int l = 0; l < LANES; l++)
      for (int w = 0; w < WORDS; w++)
        col[l][8*w +: 8] = mem[w][8*l +: 8];
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_quiet
      // R3: a lane without enable keeps its stored bytes in every word
      a_r3_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !we[g] |=> $stable(col[g]));
    end
  endgenerate
endmodule

// File: rtl/byte_lane_qual.sv
module byte_lane_qual
  import bq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WORDS = 4,
  localparam int OFFW = $clog2(LANES),
  localparam int IDXW = $clog2(WORDS),
  localparam int AW   = OFFW + IDXW,
  localparam int DW   = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       endian_mode,
  input  logic             bus_sel,
  input  logic             bus_ready_in,
  input  logic             bus_write,
  input  logic [1:0]       bus_trans,
  input  logic [AW-1:0]    bus_addr,
  input  logic [2:0]       bus_size,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [LANES-1:0] bus_wstrb,
  output logic [LANES-1:0] lane_we,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic             dphase;
  logic [OFFW-1:0]  cap_off;
  logic [IDXW-1:0]  cap_idx;
  logic [2:0]       cap_size;
  logic [LANES-1:0] permit;
  endian_e          mode;

  assign mode = endian_e'(endian_mode);

  bq_addr_capture #(.LANES(LANES), .WORDS(WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .ready_in(bus_ready_in),
    .write(bus_write), .trans(bus_trans), .addr(bus_addr), .size(bus_size),
    .dphase(dphase), .cap_off(cap_off), .cap_idx(cap_idx), .cap_size(cap_size)
  );

  bq_lane_window #(.LANES(LANES)) u_win (
    .off(cap_off), .size(cap_size), .mode(mode), .permit(permit)
  );

  assign lane_we = (dphase && bus_ready_in) ? (permit & bus_wstrb) : '0;

  bq_word_bank #(.LANES(LANES), .WORDS(WORDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(lane_we), .idx(cap_idx),
    .wdata(bus_wdata), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // R2: enables appear only in a live data phase
  a_r2_we_in_dphase: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> (dphase && bus_ready_in));

  // R5: a byte transfer enables at most one lane
  a_r5_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_size == 3'd0) |-> $onehot0(lane_we));

  // R5: a halfword transfer enables at most two lanes
  a_r5_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_size == 3'd1) |-> ($countones(lane_we) <= 2));

  // R7: mirrored mode keeps a low-half halfword off the low lanes
  a_r7_wi_half_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == END_WORD_INV && cap_size == 3'd1 && !cap_off[OFFW-1])
      |-> (lane_we[LANES/2-1:0] == '0));
endmodule

// File: tb/byte_lane_qual_test.sv
`timescale 1ns/1ps
module byte_lane_qual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  endian_mode = 2'b00;
  logic        bus_sel = 1'b0, bus_ready_in = 1'b1, bus_write = 1'b0;
  logic [1:0]  bus_trans = 2'b00;
  logic [3:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [3:0]  lane_we;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [31:0] model [4];
  logic [3:0]  exp_q [$];
  string       tag_q [$];
  event        chk_ev;

  always #4 clk = ~clk;

  byte_lane_qual uut (
    .clk(clk), .rst_n(rst_n), .endian_mode(endian_mode), .bus_sel(bus_sel),
    .bus_ready_in(bus_ready_in), .bus_write(bus_write), .bus_trans(bus_trans),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb), .lane_we(lane_we), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // Permitted lanes from the requirement text (R5, R6, R7, R9).
  function automatic logic [3:0] window(input logic [1:0] m, input logic [2:0] sz,
                                        input logic [1:0] off);
    logic [3:0] r;
    int lo;
    bit wi = (m == 2'b10);
    if (sz >= 3'd2) r = 4'b1111;
    else if (sz == 3'd1) begin
      lo = off[1] ? 2 : 0;
      r = '0;
      if (wi) begin r[3-lo] = 1'b1; r[2-lo] = 1'b1; end
      else    begin r[lo] = 1'b1;   r[lo+1] = 1'b1; end
    end else begin
      r = '0;
      r[wi ? 3 - int'(off) : int'(off)] = 1'b1;
    end
    return r;
  endfunction

  // Monitor: pops the expected enable vector for each data-phase cycle.
  initial begin
    forever begin
      @(chk_ev);
      #1;
      begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (lane_we !== e) begin
          miscompares++;
          $display("FAIL %s lane_we actual=%b expected=%b", t, lane_we, e);
        end
      end
    end
  end

  task automatic check_word(input int idx, input string t);
    @(negedge clk);
    rd_idx = 2'(idx);
    #1;
    vectors++;
    if (rd_data !== model[idx]) begin
      miscompares++;
      $display("FAIL %s word%0d actual=%h expected=%h", t, idx, rd_data, model[idx]);
    end
  endtask

  // Driver: one address phase, one (possibly stalled) data phase, then readback.
  task automatic xfer(input logic [1:0] m, input bit sel, input bit wr,
                      input logic [1:0] tr, input int idx, input logic [1:0] off,
                      input logic [2:0] sz, input logic [3:0] strb,
                      input logic [31:0] data, input int stall, input string t);
    logic [3:0] e;
    bit ok;
    @(negedge clk);
    endian_mode = m; bus_sel = sel; bus_write = wr; bus_trans = tr;
    bus_addr = {2'(idx), off}; bus_size = sz; bus_ready_in = 1'b1;
    ok = sel && wr && tr[1];
    e = ok ? (window(m, sz, off) & strb) : 4'b0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_trans = 2'b00; bus_write = 1'b0;
    bus_wdata = data; bus_wstrb = strb;
    for (int s = 0; s < stall; s++) begin
      bus_ready_in = 1'b0;
      bus_addr = ~bus_addr; bus_size = ~bus_size;
      exp_q.push_back(4'b0000); tag_q.push_back({t, " R11 stalled"});
      -> chk_ev;
      @(negedge clk);
    end
    bus_ready_in = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    -> chk_ev;
    for (int l = 0; l < 4; l++) if (e[l]) model[idx][8*l +: 8] = data[8*l +: 8];
    check_word(idx, t);
    bus_wstrb = '0;
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state of every word
    for (int w = 0; w < 4; w++) check_word(w, "R10 reset");
    // R8 / R10: full word, all strobes, each word index
    for (int w = 0; w < 4; w++)
      xfer(2'b00, 1, 1, 2'b10, w, 2'b00, 3'd2, 4'hF, 32'h11223344 + w, 0, "R8 R10 word");
    // R6: byte offsets little-endian, strobes all set
    for (int o = 0; o < 4; o++)
      xfer(2'b00, 1, 1, 2'b11, 1, 2'(o), 3'd0, 4'hF, 32'hA0B0C0D0 + o, 0, "R6 byte LE");
    // R4: halfword at offset 2, strobe 0111 writes only lane 2
    xfer(2'b00, 1, 1, 2'b10, 2, 2'b10, 3'd1, 4'b0111, 32'h55667788, 0, "R4 half 0x2");
    // R6: byte-invariant halfword low half
    xfer(2'b01, 1, 1, 2'b10, 3, 2'b00, 3'd1, 4'hF, 32'hCAFE0001, 0, "R6 half BI");
    // R7: word-invariant halfword and byte mirroring
    xfer(2'b10, 1, 1, 2'b10, 3, 2'b00, 3'd1, 4'hF, 32'hBEEF0002, 0, "R7 half WI lo");
    xfer(2'b10, 1, 1, 2'b10, 0, 2'b10, 3'd1, 4'hF, 32'h12345678, 0, "R7 half WI hi");
    xfer(2'b10, 1, 1, 2'b10, 1, 2'b00, 3'd0, 4'hF, 32'h9ABCDEF0, 0, "R7 byte WI off0");
    xfer(2'b10, 1, 1, 2'b11, 1, 2'b11, 3'd0, 4'hF, 32'h0F0E0D0C, 0, "R7 byte WI off3");
    // R9: reserved mode acts little-endian
    xfer(2'b11, 1, 1, 2'b10, 2, 2'b01, 3'd0, 4'hF, 32'h77777777, 0, "R9 mode3 byte");
    // R3: strobe subset inside the window
    xfer(2'b00, 1, 1, 2'b10, 0, 2'b00, 3'd2, 4'b1010, 32'hFFEEDDCC, 0, "R3 strobe subset");
    // R5: size code above word opens all lanes
    xfer(2'b00, 1, 1, 2'b10, 1, 2'b11, 3'd5, 4'hF, 32'h31415926, 0, "R5 size5");
    // R1: reads, idle, busy and unselected phases write nothing
    xfer(2'b00, 1, 0, 2'b10, 0, 2'b00, 3'd2, 4'hF, 32'hDEADDEAD, 0, "R1 read");
    xfer(2'b00, 1, 1, 2'b00, 0, 2'b00, 3'd2, 4'hF, 32'hDEADDEAD, 0, "R1 idle");
    xfer(2'b00, 1, 1, 2'b01, 0, 2'b00, 3'd2, 4'hF, 32'hDEADDEAD, 0, "R1 busy");
    xfer(2'b00, 0, 1, 2'b10, 0, 2'b00, 3'd2, 4'hF, 32'hDEADDEAD, 0, "R1 unselected");
    // R11 / R2: stalled data phases
    xfer(2'b00, 1, 1, 2'b10, 2, 2'b00, 3'd1, 4'hF, 32'h600D600D, 3, "R2 R11 stall LE");
    xfer(2'b10, 1, 1, 2'b11, 3, 2'b01, 3'd0, 4'hF, 32'h5A5A5A5A, 2, "R11 stall WI");
    // Mixed patterns (R3 R5 R6 R7)
    for (int k = 0; k < 40; k++)
      xfer(2'($urandom_range(0, 3)), 1, 1, 2'($urandom_range(2, 3)),
           $urandom_range(0, 3), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 3)),
           4'($urandom_range(0, 15)), $urandom, $urandom_range(0, 1), "R3 mixed");
    for (int w = 0; w < 4; w++) check_word(w, "R10 final");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule